// File: doc/BRIEF.md
# Three-Address Integer Core

This block is a single-cycle 32-bit integer processor for a small register-to-register instruction subset. Every instruction reads up to two registers and writes at most one, all in the same clock cycle. The subset has the six register logic and arithmetic operations, an add with a signed 16-bit constant, two compare-and-branch forms, an absolute jump and a jump through a register. Instructions are 32 bits wide, and the top 6 bits select one of three layouts: register, immediate or jump.

A host fills the internal instruction memory through a valid/ready load port while the core is halted (`run` low). It then raises `run`, and the core fetches from byte address 0 after reset. A load beat is taken only on a cycle where `load_valid` and `load_ready` are both high. `load_ready` is held low the whole time `run` is high, so a host keeps its beat on the port, unchanged, until the core halts. A combinational debug port returns any register, which lets the host inspect results. `pc_o` shows the current fetch address.

Top module: `tri_core`

## Requirements
- R1: While `rst_n` is low, the PC is cleared to 0 and all 32 registers are cleared to 0.
- R2: Opcode 000000 with shamt zero performs rd = rs OP rt. The funct codes are add 100000, sub 100010, and 100100, or 100101, xor 100110 and nor 100111. Field order, most significant first, is opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]. The PC advances by 4.
- R3: Opcode 001000 (immediate add) writes rt = rs + sign-extended imm[15:0], so the constant ranges from -32768 to +32767.
- R4: Register 0 always reads as zero, and writes aimed at it have no effect.
- R5: Opcode 000100 branches to PC + 4*sext(imm) when rs equals rt. Otherwise it goes to PC + 4. It never writes a register.
- R6: Opcode 000101 branches to PC + 4*sext(imm) when rs differs from rt. Otherwise it goes to PC + 4.
- R7: Opcode 000010 jumps to {(PC+4)[31:28], instr[25:0], 00}.
- R8: Opcode 000000 with funct 001000 and shamt zero sets the PC to the value of rs.
- R9: The following act as no-ops that write nothing and advance the PC by 4: any other opcode, any other funct, a nonzero shamt in the register layout, and a fetch from an address that is misaligned or beyond the memory.
- R10: `dbg_data` shows register `dbg_idx` combinationally. When that register is written in the same cycle, `dbg_data` shows the old value until the clock edge.
- R11: `load_ready` is high exactly when `run` is low. A beat with `load_valid` and `load_ready` both high writes `load_data` to word `load_addr`. While `run` is low, neither the PC nor the registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute one instruction per cycle when high |
| load_valid | input | 1 | Load beat offered |
| load_ready | output | 1 | Load beat can be taken (core halted) |
| load_addr | input | IAW | Word index in instruction memory |
| load_data | input | 32 | Instruction word to store |
| dbg_idx | input | 5 | Register to observe |
| dbg_data | output | 32 | Value of register `dbg_idx` |
| pc_o | output | 32 | Current fetch byte address |

## Verification
The checker watches every cycle for the following: the zero register reads as zero, the PC advances by 4 after each register-layout operation, branches and jumps reach their targets, and a halted core's PC stays put. Several behaviours can only be shown by the bench's scenarios. These are the ALU results and sign extension seen through the debug port, the absence of writes from skipped and undefined instructions, the old value on a same-cycle debug read, and a load beat refused while the core runs.

// File: rtl/tri_core_pkg.sv
package tri_core_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_JMP  = 6'b000010;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_BNE  = 6'b000101;
  localparam logic [5:0] OP_ADDI = 6'b001000;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_JR  = 6'b001000;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR
  } alu_op_e;

  typedef struct packed {
    alu_op_e        op;
    logic           use_imm;
    logic           wr_en;
    logic [RAW-1:0] wr_addr;
    logic           br_eq;
    logic           br_ne;
    logic           jmp;
    logic           jreg;
  } ctrl_t;
endpackage

// File: rtl/tri_decode.sv
module tri_decode
  import tri_core_pkg::*;
(
  input  logic [5:0]     opcode,
  input  logic [RAW-1:0] rt,
  input  logic [RAW-1:0] rd,
  input  logic [4:0]     shamt,
  input  logic [5:0]     funct,
  output ctrl_t          ctl
);
  always_comb begin
    ctl = '{op: ALU_ADD, use_imm: 1'b0, wr_en: 1'b0, wr_addr: '0,
            br_eq: 1'b0, br_ne: 1'b0, jmp: 1'b0, jreg: 1'b0};
    unique case (opcode)
      OP_REG: begin
        if (shamt == 5'd0) begin
          ctl.wr_addr = rd;
          unique case (funct)
            FN_ADD: begin ctl.op = ALU_ADD; ctl.wr_en = 1'b1; end
            FN_SUB: begin ctl.op = ALU_SUB; ctl.wr_en = 1'b1; end
            FN_AND: begin ctl.op = ALU_AND; ctl.wr_en = 1'b1; end
            FN_OR:  begin ctl.op = ALU_OR;  ctl.wr_en = 1'b1; end
            FN_XOR: begin ctl.op = ALU_XOR; ctl.wr_en = 1'b1; end
            FN_NOR: begin ctl.op = ALU_NOR; ctl.wr_en = 1'b1; end
            FN_JR:  ctl.jreg = 1'b1;
            default: ;
          endcase
        end
      end
      OP_ADDI: begin
        ctl.op      = ALU_ADD;
        ctl.use_imm = 1'b1;
        ctl.wr_en   = 1'b1;
        ctl.wr_addr = rt;
      end
      OP_BEQ: ctl.br_eq = 1'b1;
      OP_BNE: ctl.br_ne = 1'b1;
      OP_JMP: ctl.jmp   = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tri_alu.sv
module tri_alu
  import tri_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tri_regfile.sv
module tri_regfile
  import tri_core_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int N    = NREG,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra [NRD],
  output logic [W-1:0]  rd [NRD]
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end
endmodule

// File: rtl/tri_core.sv
module tri_core
  import tri_core_pkg::*;
#(
  parameter int  IMEM_WORDS = 64,
  localparam int IAW        = $clog2(IMEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [IAW-1:0]   load_addr,
  input  logic [XLEN-1:0]  load_data,
  input  logic [RAW-1:0]   dbg_idx,
  output logic [XLEN-1:0]  dbg_data,
  output logic [XLEN-1:0]  pc_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] pc_q, pc_nxt, pc_inc, br_tgt;
  logic [XLEN-1:0] instr, imm_ext, opb, alu_y;
  logic [XLEN-1:0] rs_val, rt_val;
  logic            fetch_ok, same;
  ctrl_t           ctl;
  logic [RAW-1:0]  rf_ra [3];
  logic [XLEN-1:0] rf_rd [3];

  assign load_ready = !run;

  always_ff @(posedge clk) begin
    if (load_valid && load_ready) imem[load_addr] <= load_data;
  end

  assign fetch_ok = (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:IAW+2] == '0);
  assign instr    = fetch_ok ? imem[pc_q[IAW+1:2]] : '0;

  tri_decode u_dec (
    .opcode(instr[31:26]),
    .rt    (instr[20:16]),
    .rd    (instr[15:11]),
    .shamt (instr[10:6]),
    .funct (instr[5:0]),
    .ctl   (ctl)
  );

  assign rf_ra[0] = instr[25:21];
  assign rf_ra[1] = instr[20:16];
  assign rf_ra[2] = dbg_idx;
  assign rs_val   = rf_rd[0];
  assign rt_val   = rf_rd[1];
  assign dbg_data = rf_rd[2];

  tri_regfile #(.W(XLEN), .N(NREG), .NRD(3)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (run && ctl.wr_en),
    .wa   (ctl.wr_addr),
    .wd   (alu_y),
    .ra   (rf_ra),
    .rd   (rf_rd)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign opb     = ctl.use_imm ? imm_ext : rt_val;

  tri_alu #(.W(XLEN)) u_alu (
    .op(ctl.op),
    .a (rs_val),
    .b (opb),
    .y (alu_y)
  );

  assign pc_inc = pc_q + XLEN'(4);
  assign br_tgt = pc_q + {imm_ext[XLEN-3:0], 2'b00};
  assign same   = (rs_val == rt_val);

  always_comb begin
    pc_nxt = pc_inc;
    if (ctl.jreg)
      pc_nxt = rs_val;
    else if (ctl.jmp)
      pc_nxt = {pc_inc[XLEN-1:28], instr[25:0], 2'b00};
    else if ((ctl.br_eq && same) || (ctl.br_ne && !same))
      pc_nxt = br_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/tri_core_chk.sv
module tri_core_chk
  import tri_core_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [RAW-1:0]  dbg_idx,
  input logic [XLEN-1:0] dbg_data,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val
);
  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_idx == '0 |-> dbg_data == '0);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && instr[31:26] == OP_REG && instr[5:0] != FN_JR
    |=> pc_q == $past(pc_q) + XLEN'(4));

  // R5
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && instr[31:26] == OP_BEQ && rs_val == rt_val
    |=> pc_q == $past(pc_q + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00}));

  // R6
  bne_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && instr[31:26] == OP_BNE && rs_val != rt_val
    |=> pc_q == $past(pc_q + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00}));

  // R7
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && instr[31:26] == OP_JMP
    |=> pc_q[27:0] == $past({instr[25:0], 2'b00}));

  // R8
  jreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && instr[31:26] == OP_REG && instr[10:0] == {5'd0, FN_JR}
    |=> pc_q == $past(rs_val));

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc_q));
endmodule

bind tri_core tri_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .dbg_idx (dbg_idx),
  .dbg_data(dbg_data),
  .pc_q    (pc_q),
  .instr   (instr),
  .rs_val  (rs_val),
  .rt_val  (rt_val)
);

// File: tb/sim_tri_core.sv
`timescale 1ns/1ps
module sim_tri_core;
  localparam int WORDS = 64;
  localparam int IAW   = $clog2(WORDS);

  logic           clk = 0;
  logic           rst_n = 0;
  logic           run = 0;
  logic           load_valid = 0;
  logic           load_ready;
  logic [IAW-1:0] load_addr = '0;
  logic [31:0]    load_data = '0;
  logic [4:0]     dbg_idx = '0;
  logic [31:0]    dbg_data;
  logic [31:0]    pc_o;

  tri_core #(.IMEM_WORDS(WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data), .pc_o(pc_o)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: kind 0 = register value, kind 1 = PC value
  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] val;
    int          req;
  } exp_t;
  exp_t sb[$];
  bit   mon_busy = 0;

  task automatic push_reg(input int idx, input logic [31:0] val, input int req);
    exp_t e;
    e.kind = 0; e.idx = idx; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic push_pc(input logic [31:0] val, input int req);
    exp_t e;
    e.kind = 1; e.idx = 0; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drain();
    wait (sb.size() == 0 && !mon_busy);
  endtask

  initial begin : monitor
    exp_t        it;
    logic [31:0] act;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      mon_busy = 1;
      @(negedge clk);
      if (it.kind == 0) dbg_idx = it.idx[4:0];
      #2;
      act = (it.kind == 0) ? dbg_data : pc_o;
      chk(act == it.val, $sformatf("R%0d idx=%0d kind=%0d", it.req, it.idx, it.kind), act, it.val);
      mon_busy = 0;
    end
  end

  function automatic logic [31:0] rins(input logic [5:0] fn, input int rs, input int rt, input int rd);
    logic [4:0] a = rs[4:0], b = rt[4:0], c = rd[4:0];
    return {6'b000000, a, b, c, 5'd0, fn};
  endfunction

  function automatic logic [31:0] iins(input logic [5:0] op, input int rs, input int rt, input int imm);
    logic [4:0]  a = rs[4:0], b = rt[4:0];
    logic [15:0] k = imm[15:0];
    return {op, a, b, k};
  endfunction

  function automatic logic [31:0] jins(input int word);
    logic [25:0] t = word[25:0];
    return {6'b000010, t};
  endfunction

  task automatic load(input int addr, input logic [31:0] data);
    @(negedge clk);
    load_valid = 1;
    load_addr  = addr[IAW-1:0];
    load_data  = data;
    @(negedge clk);
    load_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] prog [27];
    prog[0]  = iins(6'b001000, 0, 8, 5);
    prog[1]  = iins(6'b001000, 0, 9, -3);
    prog[2]  = rins(6'b100000, 8, 9, 10);
    prog[3]  = rins(6'b100010, 8, 9, 11);
    prog[4]  = rins(6'b100100, 8, 9, 12);
    prog[5]  = rins(6'b100101, 8, 9, 13);
    prog[6]  = rins(6'b100110, 8, 9, 14);
    prog[7]  = rins(6'b100111, 8, 9, 15);
    prog[8]  = iins(6'b001000, 8, 0, 7);
    prog[9]  = 32'hFC00_0000;
    prog[10] = rins(6'b000001, 8, 9, 16);
    prog[11] = iins(6'b000100, 8, 8, 3);
    prog[12] = iins(6'b001000, 0, 17, 1);
    prog[13] = iins(6'b001000, 0, 17, 2);
    prog[14] = iins(6'b000101, 8, 8, 2);
    prog[15] = iins(6'b000101, 8, 9, 2);
    prog[16] = iins(6'b001000, 0, 17, 3);
    prog[17] = iins(6'b000100, 8, 9, 5);
    prog[18] = iins(6'b001000, 0, 18, 32767);
    prog[19] = iins(6'b001000, 0, 19, -32768);
    prog[20] = jins(23);
    prog[21] = iins(6'b001000, 0, 17, 4);
    prog[22] = iins(6'b001000, 0, 17, 4);
    prog[23] = iins(6'b001000, 0, 20, 104);
    prog[24] = rins(6'b001000, 20, 0, 0);
    prog[25] = iins(6'b001000, 0, 17, 5);
    prog[26] = jins(26);

    do_reset();
    // R1: reset state
    push_pc(32'h0, 1);
    push_reg(8, 32'h0, 1);
    drain();
    #1;
    // R11: ready while halted
    chk(load_ready == 1'b1, "R11 ready when halted", {31'd0, load_ready}, 32'h1);

    for (int i = 0; i < 27; i++) load(i, prog[i]);

    @(negedge clk);
    run = 1;
    repeat (40) @(negedge clk);
    run = 0;

    push_reg(8,  32'h0000_0005, 3);   // R3
    push_reg(9,  32'hFFFF_FFFD, 3);   // R3 negative constant
    push_reg(10, 32'h0000_0002, 2);   // R2 add
    push_reg(11, 32'h0000_0008, 2);   // R2 sub
    push_reg(12, 32'h0000_0005, 2);   // R2 and
    push_reg(13, 32'hFFFF_FFFD, 2);   // R2 or
    push_reg(14, 32'hFFFF_FFF8, 2);   // R2 xor
    push_reg(15, 32'h0000_0002, 2);   // R2 nor
    push_reg(0,  32'h0000_0000, 4);   // R4 write to register 0 ignored
    push_reg(16, 32'h0000_0000, 9);   // R9 undefined funct writes nothing
    push_reg(17, 32'h0000_0000, 5);   // R5 R6 R7 R8 skipped instructions
    push_reg(18, 32'h0000_7FFF, 3);   // R3 largest constant
    push_reg(19, 32'hFFFF_8000, 3);   // R3 smallest constant
    push_reg(20, 32'h0000_0068, 8);   // R8 jump target register
    push_pc(32'h0000_0068, 7);        // R7 R8 self loop reached
    drain();
    repeat (5) @(negedge clk);
    push_pc(32'h0000_0068, 11);       // R11 PC holds while halted
    drain();

    // R10 and R11 second scenario
    do_reset();
    push_reg(9, 32'h0, 1);            // R1 registers cleared
    push_pc(32'h0, 1);
    drain();
    load(0, iins(6'b001000, 0, 8, 9));
    load(1, jins(1));
    @(negedge clk);
    dbg_idx = 5'd8;
    run = 1;
    #5;
    chk(dbg_data == 32'h0, "R10 same-cycle read old value", dbg_data, 32'h0);
    @(posedge clk);
    #5;
    chk(dbg_data == 32'h9, "R10 value after edge", dbg_data, 32'h9);
    @(negedge clk);
    load_valid = 1;
    load_addr  = 1;
    load_data  = iins(6'b001000, 0, 9, 1);
    repeat (3) begin
      #2;
      chk(load_ready == 1'b0, "R11 not ready while running", {31'd0, load_ready}, 32'h0);
      @(negedge clk);
    end
    load_valid = 0;
    repeat (4) @(negedge clk);
    run = 0;
    push_reg(9, 32'h0, 11);           // R11 refused beat had no effect
    push_pc(32'h4, 11);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule